// File: doc/BRIEF.md
# Boxed Multi-Precision Floating-Point Register File

This block holds the floating-point architectural state of a core that handles single, double and quad precision in one set of 128-bit registers. A value narrower than 128 bits is padded with ones above it when it is written (NaN-boxing). The padding goes up to the full register width, so each register holds one encoding that every format can interpret.

On a read, each port names a register and the precision it wants. The port checks the padding for that precision and returns either the payload or the canonical quiet NaN of that precision. The padding is nested. A single-precision value counts as valid only when both the 64-bit padding above a double and the 32-bit padding above the single are intact. Quad reads return the raw register with no check.

Each read port also has two raw views of the low bits: the low 64 bits, and the low 32 bits sign-extended to 64. Integer move operations use these views, and they never check the padding. There is one synchronous write port and a parameterised number of combinational read ports.

Top module: `fpr_box_regfile`

## Requirements
- R1: A write with format code 2'b00 (single) stores wr_data[31:0] in bits 31:0 and sets bits 127:32 of the register to all ones.
- R2: A write with format code 2'b01 (double) stores wr_data[63:0] in bits 63:0 and sets bits 127:64 to all ones.
- R3: A write with format code 2'b11 (quad) stores all 128 bits of wr_data unchanged.
- R4: Format code 2'b10 behaves as quad on both the write port and the read ports.
- R5: A read with format 2'b01 returns {64'b0, bits 63:0} when bits 127:64 are all ones, and otherwise returns {64'b0, 64'h7FF8000000000000}.
- R6: A read with format 2'b00 returns {96'b0, bits 31:0} only when bits 127:32 are all ones, and otherwise returns {96'b0, 32'h7FC00000}.
- R7: A read with format 2'b11 returns the raw 128-bit register contents.
- R8: On every port, rd_lo64 equals register bits 63:0 and rd_lo32sx equals bits 31:0 sign-extended to 64 bits, whatever the padding holds.
- R9: A read of a register in the same cycle that the register is written returns the contents from before the write. The new value appears from the next cycle.
- R10: Reset clears every register to zero, so a cleared register reads as the canonical NaN in single and double format and as zero in quad format.
- R11: While wr_en is low, no register changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Register written |
| wr_fmt | input | 2 | Precision of the written value |
| wr_data | input | 128 | Value written; narrow formats use the low bits |
| rd_addr | input | RD_PORTS x AW | Register read per port |
| rd_fmt | input | RD_PORTS x 2 | Precision requested per port |
| rd_val | output | RD_PORTS x 128 | Unboxed value, zero above the payload |
| rd_lo64 | output | RD_PORTS x 64 | Raw low 64 bits |
| rd_lo32sx | output | RD_PORTS x 64 | Raw low 32 bits, sign-extended |

## Verification
The bench uses the default parameters: 32 registers and two read ports. With two ports, one register can be read in two precisions in the same cycle, and a read can be aimed at the register being written while the other port reads elsewhere. Random write data is shaped so that often only the outer or only the inner padding level is intact. This exercises both layers of the nested single-precision check, and the directed cases cover the cleared state after reset and the alias code 2'b10.

// File: rtl/fpr_box_pkg.sv
package fpr_box_pkg;

    localparam int QW = 128;
    localparam int DW = 64;
    localparam int SW = 32;

    typedef enum logic [1:0] {
        FMT_SGL  = 2'b00,
        FMT_DBL  = 2'b01,
        FMT_ALT  = 2'b10,
        FMT_QUAD = 2'b11
    } fmt_e;

    localparam logic [DW-1:0] CANON_DBL = 64'h7FF8_0000_0000_0000;
    localparam logic [SW-1:0] CANON_SGL = 32'h7FC0_0000;

endpackage

// File: rtl/fpr_boxer.sv
module fpr_boxer
    import fpr_box_pkg::*;
(
    input  logic [1:0]    fmt,
    input  logic [QW-1:0] data,
    output logic [QW-1:0] boxed
);

    always_comb begin
        unique case (fmt_e'(fmt))
            FMT_SGL: boxed = {{(QW-SW){1'b1}}, data[SW-1:0]};
            FMT_DBL: boxed = {{(QW-DW){1'b1}}, data[DW-1:0]};
            default: boxed = data;
        endcase
    end

endmodule

// File: rtl/fpr_unboxer.sv
module fpr_unboxer
    import fpr_box_pkg::*;
(
    input  logic [QW-1:0] entry,
    input  logic [1:0]    fmt,
    output logic [QW-1:0] val,
    output logic [DW-1:0] lo64,
    output logic [DW-1:0] lo32sx
);

    logic outer_ok;
    logic inner_ok;

    always_comb begin
        outer_ok = &entry[QW-1:DW];
        inner_ok = outer_ok & (&entry[DW-1:SW]);
        unique case (fmt_e'(fmt))
            FMT_SGL: val = {{(QW-SW){1'b0}}, inner_ok ? entry[SW-1:0] : CANON_SGL};
            FMT_DBL: val = {{(QW-DW){1'b0}}, outer_ok ? entry[DW-1:0] : CANON_DBL};
            default: val = entry;
        endcase
        lo64   = entry[DW-1:0];
        lo32sx = {{(DW-SW){entry[SW-1]}}, entry[SW-1:0]};
    end

endmodule

// File: rtl/fpr_box_regfile.sv
module fpr_box_regfile
    import fpr_box_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int RD_PORTS = 2,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [AW-1:0]                    wr_addr,
    input  logic [1:0]                       wr_fmt,
    input  logic [QW-1:0]                    wr_data,
    input  logic [RD_PORTS-1:0][AW-1:0]      rd_addr,
    input  logic [RD_PORTS-1:0][1:0]         rd_fmt,
    output logic [RD_PORTS-1:0][QW-1:0]      rd_val,
    output logic [RD_PORTS-1:0][DW-1:0]      rd_lo64,
    output logic [RD_PORTS-1:0][DW-1:0]      rd_lo32sx
);

    typedef struct packed {
        logic [DEPTH-1:0][QW-1:0] mem;
    } state_t;

    state_t        st_d;
    state_t        st_q;
    logic [QW-1:0] wr_boxed;

    fpr_boxer u_boxer (
        .fmt   (wr_fmt),
        .data  (wr_data),
        .boxed (wr_boxed)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[wr_addr] = wr_boxed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        fpr_unboxer u_unbox (
            .entry  (st_q.mem[rd_addr[p]]),
            .fmt    (rd_fmt[p]),
            .val    (rd_val[p]),
            .lo64   (rd_lo64[p]),
            .lo32sx (rd_lo32sx[p])
        );
    end

endmodule

// File: rtl/fpr_box_chk.sv
module fpr_box_chk
    import fpr_box_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int RD_PORTS = 2,
    localparam int AW      = $clog2(DEPTH)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [AW-1:0]               wr_addr,
    input logic [1:0]                  wr_fmt,
    input logic [QW-1:0]               wr_data,
    input logic [RD_PORTS-1:0][AW-1:0] rd_addr,
    input logic [RD_PORTS-1:0][1:0]    rd_fmt,
    input logic [RD_PORTS-1:0][QW-1:0] rd_val,
    input logic [RD_PORTS-1:0][DW-1:0] rd_lo64,
    input logic [DEPTH-1:0][QW-1:0]    mem
);

    a_r1_single_box: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fmt == 2'b00) |=>
            mem[$past(wr_addr)] == {{(QW-SW){1'b1}}, $past(wr_data[SW-1:0])});

    a_r2_double_box: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fmt == 2'b01) |=>
            mem[$past(wr_addr)] == {{(QW-DW){1'b1}}, $past(wr_data[DW-1:0])});

    // R3 and R4: codes 2'b11 and 2'b10 both store raw
    a_r3_quad_raw_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fmt[1]) |=> mem[$past(wr_addr)] == $past(wr_data));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> mem == $past(mem));

    a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> mem == '0);

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_p
        a_r6_single_canon: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_fmt[p] == 2'b00 && !(&mem[rd_addr[p]][QW-1:SW])) |->
                rd_val[p] == {{(QW-SW){1'b0}}, CANON_SGL});

        a_r5_double_canon: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_fmt[p] == 2'b01 && !(&mem[rd_addr[p]][QW-1:DW])) |->
                rd_val[p] == {{(QW-DW){1'b0}}, CANON_DBL});

        a_r7_quad_read: assert property (@(posedge clk) disable iff (!rst_n)
            rd_fmt[p][1] |-> rd_val[p] == mem[rd_addr[p]]);

        a_r8_raw_low: assert property (@(posedge clk) disable iff (!rst_n)
            rd_lo64[p] == mem[rd_addr[p]][DW-1:0]);
    end

endmodule

bind fpr_box_regfile fpr_box_chk #(.DEPTH(DEPTH), .RD_PORTS(RD_PORTS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_fmt  (wr_fmt),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_fmt  (rd_fmt),
    .rd_val  (rd_val),
    .rd_lo64 (rd_lo64),
    .mem     (st_q.mem)
);

// File: tb/sim_fpr_box_regfile.sv
module sim_fpr_box_regfile;

    localparam int DEPTH = 32;
    localparam int NP    = 2;
    localparam int AW    = 5;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic                    wr_en;
    logic [AW-1:0]           wr_addr;
    logic [1:0]              wr_fmt;
    logic [127:0]            wr_data;
    logic [NP-1:0][AW-1:0]   rd_addr;
    logic [NP-1:0][1:0]      rd_fmt;
    logic [NP-1:0][127:0]    rd_val;
    logic [NP-1:0][63:0]     rd_lo64;
    logic [NP-1:0][63:0]     rd_lo32sx;

    logic [127:0] model [DEPTH];
    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fpr_box_regfile #(.DEPTH(DEPTH), .RD_PORTS(NP)) u0 (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_fmt, .wr_data,
        .rd_addr, .rd_fmt, .rd_val, .rd_lo64, .rd_lo32sx
    );

    function automatic logic [127:0] box(logic [1:0] f, logic [127:0] d);
        if (f == 2'b00) return {{96{1'b1}}, d[31:0]};
        if (f == 2'b01) return {{64{1'b1}}, d[63:0]};
        return d;
    endfunction

    function automatic logic [127:0] unbox(logic [127:0] e, logic [1:0] f);
        if (f == 2'b00)
            return (e[127:32] == {96{1'b1}}) ? {96'b0, e[31:0]} : {96'b0, 32'h7FC00000};
        if (f == 2'b01)
            return (e[127:64] == {64{1'b1}}) ? {64'b0, e[63:0]} : {64'b0, 64'h7FF8000000000000};
        return e;
    endfunction

    function automatic string fmt_tag(logic [1:0] f);
        case (f)
            2'b00:   return "R6";
            2'b01:   return "R5";
            2'b10:   return "R4";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Drive at negedge, check reads before the next edge, then apply the write to the model.
    task automatic step(logic we, logic [AW-1:0] wa, logic [1:0] wf, logic [127:0] wd,
                        logic [AW-1:0] a0, logic [1:0] f0,
                        logic [AW-1:0] a1, logic [1:0] f1, string tag);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_fmt = wf; wr_data = wd;
        rd_addr[0] = a0; rd_fmt[0] = f0;
        rd_addr[1] = a1; rd_fmt[1] = f1;
        #3;
        for (int p = 0; p < NP; p++) begin
            logic [127:0] e;
            e = model[rd_addr[p]];
            chk(tag == "" ? fmt_tag(rd_fmt[p]) : tag, rd_val[p], unbox(e, rd_fmt[p]));
            chk("R8", {64'b0, rd_lo64[p]}, {64'b0, e[63:0]});
            chk("R8", {64'b0, rd_lo32sx[p]}, {64'b0, {32{e[31]}}, e[31:0]});
        end
        if (we) model[wa] = box(wf, wd);
    endtask

    function automatic logic [127:0] rand_data();
        logic [127:0] d;
        int sel;
        d = {$urandom, $urandom, $urandom, $urandom};
        sel = $urandom_range(0, 3);
        if (sel == 1) d[127:64] = '1;
        if (sel == 2) d[127:32] = '1;
        if (sel == 3) d[95:32]  = '1;
        return d;
    endfunction

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_fmt = '0; wr_data = '0;
        rd_addr = '0; rd_fmt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10: cleared registers in every format
        for (int r = 0; r < DEPTH; r++) begin
            step(1'b0, '0, 2'b00, '1, AW'(r), 2'b00, AW'(r), 2'b01, "R10");
            step(1'b0, '0, 2'b00, '1, AW'(r), 2'b11, AW'(r), 2'b10, "R10");
        end

        // R1, R2, R3: write then inspect raw through a quad read
        step(1'b1, 5'd3, 2'b00, 128'h0123_4567_89AB_CDEF_1122_3344_3F80_0000,
             5'd0, 2'b11, 5'd1, 2'b11, "");
        step(1'b0, '0, 2'b00, '0, 5'd3, 2'b11, 5'd3, 2'b00, "R1");
        step(1'b1, 5'd4, 2'b01, 128'h0000_1111_2222_3333_4009_21FB_5444_2D18,
             5'd0, 2'b11, 5'd1, 2'b11, "");
        step(1'b0, '0, 2'b00, '0, 5'd4, 2'b11, 5'd4, 2'b01, "R2");
        step(1'b1, 5'd5, 2'b11, 128'h4000_0000_1234_5678_9ABC_DEF0_0F0F_0F0F,
             5'd0, 2'b11, 5'd1, 2'b11, "");
        step(1'b0, '0, 2'b00, '0, 5'd5, 2'b11, 5'd5, 2'b01, "R3");
        // R4: alias code writes raw and reads raw
        step(1'b1, 5'd6, 2'b10, 128'h0000_0000_0000_0001_FFFF_FFFF_0000_0002,
             5'd0, 2'b11, 5'd1, 2'b11, "");
        step(1'b0, '0, 2'b00, '0, 5'd6, 2'b10, 5'd6, 2'b11, "R4");
        // R6: nested padding, outer intact but inner broken, and both intact
        step(1'b1, 5'd8, 2'b01, {64'h0, 64'h1234_5678_3F80_0000},
             5'd0, 2'b11, 5'd1, 2'b11, "");
        step(1'b1, 5'd9, 2'b01, {64'h0, 64'hFFFF_FFFF_3F80_0000},
             5'd8, 2'b00, 5'd8, 2'b01, "R6");
        step(1'b0, '0, 2'b00, '0, 5'd9, 2'b00, 5'd9, 2'b01, "R6");
        // R5: quad value with broken outer padding read as double
        step(1'b1, 5'd10, 2'b11, 128'hFFFF_FFFF_FFFF_FFFE_0000_0000_0000_0007,
             5'd0, 2'b11, 5'd1, 2'b11, "");
        step(1'b0, '0, 2'b00, '0, 5'd10, 2'b01, 5'd10, 2'b00, "R5");
        // R9: same-cycle read sees the old value, the next cycle sees the new
        step(1'b1, 5'd5, 2'b01, 128'hDEAD_BEEF, 5'd5, 2'b11, 5'd5, 2'b01, "R9");
        step(1'b0, '0, 2'b00, '0, 5'd5, 2'b11, 5'd5, 2'b01, "R9");
        // R11: disabled write leaves register 3 untouched
        step(1'b0, 5'd3, 2'b11, '0, 5'd0, 2'b11, 5'd1, 2'b11, "");
        step(1'b0, '0, 2'b00, '0, 5'd3, 2'b11, 5'd3, 2'b00, "R11");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            step(1'($urandom_range(0, 1)), AW'($urandom), 2'($urandom), rand_data(),
                 AW'($urandom), 2'($urandom), AW'($urandom), 2'($urandom), "");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule